// File: doc/BRIEF.md
# Simple I2C Condition Controller

This block sequences simple I2C master transactions from a small byte-wide register port. Software requests a start, a repeated start or a stop through a three-bit request field. The block reports completion through a sticky flag and a transmit-end interrupt level. The first data byte written after a condition is treated as the address byte. Its low bit sets whether the transfer reads or writes, and its upper seven bits name the target.

In a write transfer, later data bytes are held in a small queue. A repeated start or a stop drains that queue onto an abstract byte-level bus toward the target, one byte per cycle, and the condition only completes once the queue is empty. In a read transfer, writing the dummy value 0xFF asks the target for one byte. The returned bytes collect in a receive queue that software reads back. A stop in a read transfer throws away any bytes left unread.

Three interrupt outputs are provided: a one-cycle transmit pulse, a one-cycle receive pulse and a transmit-end level. Bit timing on the wires, noise filtering and arbitration are handled elsewhere.

Top module: `i2c_seq_ctrl`

## Requirements
- R1: After reset, the control, condition and status registers read 0x00, and every interrupt and bus output is low.
- R2: A data write (register 0) while idle, with transmit enable (control bit 0) set, is an address byte. Afterwards status bit 0 (active) is 1, status bit 1 (read) equals the byte's bit 0, `bus_tgt_o` equals bits 7:1, and the completion flag is cleared.
- R3: In a write transfer, data bytes are queued and never reach the bus until a stop or repeated start is pending. Then they appear on `bus_wr_valid_o`/`bus_wr_data_o` in write order, one per cycle, and the condition completes in the cycle after the last byte.
- R4: In a read transfer, a data write of 0xFF raises `bus_rd_req_o` for exactly one cycle, in the cycle after the write. Any other value is ignored: no request and no transmit pulse. No byte written in a read transfer appears on the write bus.
- R5: Bytes returned on `bus_rd_valid_i` during a read transfer are read back from register 0 in arrival order. Status bit 4 is 1 while any are held. Each accepted byte gives a one-cycle `rxi_o` pulse when control bit 3 is set. A read of an empty queue returns 0x00.
- R6: Condition register (1): bit 0 requests start, bit 1 repeated start, bit 2 stop. A request bit reads 1 while pending and clears when done. Completion sets bit 3. Writing 0 to bit 3 clears it, and writing 1 leaves it unchanged.
- R7: A condition write with more than one of bits 2:0 set performs no condition and sets sticky status bit 2. Writing 1 to status bit 2 clears it.
- R8: After any completed condition, status bits 0 and 1 read 0 and `bus_tgt_o` is 0x00.
- R9: A completed stop with a target addressed pulses `bus_end_o` for one cycle and discards unread receive bytes. A repeated start never pulses `bus_end_o`.
- R10: A stop or repeated start with no target addressed sets the completion flag without any bus activity and sets sticky status bit 3. Writing 1 to status bit 3 clears it.
- R11: `tei_o` equals control bit 2 AND the completion flag.
- R12: `txi_o` pulses for one cycle, in the cycle after each of these events, when control bit 1 was set before it: an accepted address, payload or dummy byte; a data read; a control write with bit 4 (acknowledge-transmit) set. Control bit 4 reads back as 0.
- R13: Data writes are ignored while transmit enable is 0 or a condition is pending. A payload byte arriving while the write queue is full is dropped with no transmit pulse.
- R14: A start completes in the cycle after its request. It discards queued write bytes and receive bytes without bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data on register 0) |
| reg_addr | input | 2 | Register select: 0 data, 1 condition, 2 control, 3 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| txi_o | output | 1 | Transmit interrupt pulse |
| rxi_o | output | 1 | Receive interrupt pulse |
| tei_o | output | 1 | Transmit-end interrupt level |
| bus_tgt_o | output | 7 | Address of the target of the current transfer |
| bus_wr_valid_o | output | 1 | A write byte is delivered to the target this cycle |
| bus_wr_data_o | output | 8 | Write byte |
| bus_rd_req_o | output | 1 | Request one byte from the target |
| bus_rd_valid_i | input | 1 | Target returns a byte |
| bus_rd_data_i | input | 8 | Returned byte |
| bus_end_o | output | 1 | End of transfer with the target (stop) |

## Verification
The assertions check on every cycle the properties that hold for any stimulus. At most one request is ever pending. A completed condition always leaves the tracker idle with the completion flag set. Write bytes reach the bus only while a stop or repeated start drains the queue. A read request or a transfer end only happens inside a matching transfer. An illegal multi-bit request never starts a condition. The bench scenarios show what depends on data and order: the exact byte order of a drain, the dropped fifth byte of a full queue, the dummy/non-dummy split, the receive order and the discard on stop, the sticky error bits and their clearing, and the gating of each interrupt pulse.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  // register select codes
  localparam logic [1:0] RA_DATA = 2'd0;
  localparam logic [1:0] RA_COND = 2'd1;
  localparam logic [1:0] RA_CTRL = 2'd2;
  localparam logic [1:0] RA_STAT = 2'd3;

  // condition register bits
  localparam int REQ_START   = 0;
  localparam int REQ_RESTART = 1;
  localparam int REQ_STOP    = 2;
  localparam int COND_DONE   = 3;

  // control register bits
  localparam int CTL_TXEN = 0;
  localparam int CTL_TXIE = 1;
  localparam int CTL_TEIE = 2;
  localparam int CTL_RXIE = 3;
  localparam int CTL_ACK  = 4;
  localparam int CTL_W    = 4;

  // status register bits
  localparam int ST_EMULTI = 2;
  localparam int ST_ENOTGT = 3;

  localparam logic [7:0] DUMMY_BYTE = 8'hFF;

  typedef enum logic { TS_IDLE, TS_ACTIVE } txn_state_t;
  typedef enum logic [1:0] { BK_ADDR, BK_PAYLOAD, BK_DUMMY, BK_DROP } byte_kind_t;

  // a request field is legal when no more than one bit is set
  function automatic logic req_legal(input logic [2:0] r);
    return (r & (r - 3'd1)) == 3'd0;
  endfunction

  // meaning of a written data byte given the transfer state
  function automatic byte_kind_t classify_byte(input logic active, input logic is_read,
                                               input logic [7:0] b);
    if (!active)          return BK_ADDR;
    if (!is_read)         return BK_PAYLOAD;
    if (b == DUMMY_BYTE)  return BK_DUMMY;
    return BK_DROP;
  endfunction
endpackage

// File: rtl/i2cs_fifo.sv
module i2cs_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    rp, wp;
  logic [CW-1:0]    cnt;
  logic             do_push, do_pop;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else if (clr) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= ptr_next(wp);
      if (do_pop)  rp <= ptr_next(rp);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp] <= din;
  end
endmodule

// File: rtl/i2cs_txn_tracker.sv
module i2cs_txn_tracker
  import i2cs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_ev,
  input  logic [7:0] addr_byte,
  input  logic       cond_done,
  output logic       active,
  output logic       is_read,
  output logic [6:0] tgt
);
  txn_state_t state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TS_IDLE;
      is_read <= 1'b0;
      tgt     <= '0;
    end else if (cond_done) begin
      state_q <= TS_IDLE;
      is_read <= 1'b0;
      tgt     <= '0;
    end else if (addr_ev) begin
      state_q <= TS_ACTIVE;
      is_read <= addr_byte[0];
      tgt     <= addr_byte[7:1];
    end
  end

  assign active = (state_q == TS_ACTIVE);
endmodule

// File: rtl/i2cs_cond_engine.sv
module i2cs_cond_engine
  import i2cs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_wr,
  input  logic [2:0] req_bits,
  input  logic       active,
  input  logic       is_read,
  input  logic       wq_empty,
  output logic [2:0] pend,
  output logic       complete,
  output logic       flush_pop,
  output logic       multi_ev,
  output logic       notgt_ev,
  output logic       end_ev,
  output logic       rx_clr,
  output logic       wq_clr
);
  logic accept, drain_kind;

  assign accept     = req_wr && (req_bits != 3'd0) && req_legal(req_bits) && (pend == 3'd0);
  assign multi_ev   = req_wr && !req_legal(req_bits);
  assign drain_kind = pend[REQ_RESTART] | pend[REQ_STOP];
  assign flush_pop  = drain_kind && !wq_empty;
  assign complete   = pend[REQ_START] || (drain_kind && wq_empty);
  assign end_ev     = complete && pend[REQ_STOP] && active;
  assign notgt_ev   = complete && drain_kind && !active;
  assign wq_clr     = complete && pend[REQ_START];
  assign rx_clr     = wq_clr || (end_ev && is_read);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend <= '0;
    else if (complete) pend <= '0;
    else if (accept)   pend <= req_bits;
  end
endmodule

// File: rtl/i2c_seq_ctrl.sv
module i2c_seq_ctrl
  import i2cs_pkg::*;
#(
  parameter int WQ_DEPTH = 4,
  parameter int RQ_DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       txi_o,
  output logic       rxi_o,
  output logic       tei_o,
  output logic [6:0] bus_tgt_o,
  output logic       bus_wr_valid_o,
  output logic [7:0] bus_wr_data_o,
  output logic       bus_rd_req_o,
  input  logic       bus_rd_valid_i,
  input  logic [7:0] bus_rd_data_i,
  output logic       bus_end_o
);
  // register state
  logic [CTL_W-1:0] ctrl_q;
  logic             done_q, err_multi_q, err_notgt_q;
  logic             txi_q, rxi_q, rdreq_q;

  // named internal events
  logic       txi_en_w, tei_en_w;
  logic       txn_active, txn_read;
  logic [6:0] txn_tgt;
  logic [2:0] cond_pend;
  logic       cond_complete, flush_pop, multi_ev, notgt_ev, end_ev, rx_clr, wq_clr;
  logic       req_wr, done_clr_wr, stat_wr, ctrl_wr;
  logic       data_ok, addr_ev, pay_ev, dummy_ev, rd_data, ack_ev, rx_push_ok;
  byte_kind_t kind;
  logic [7:0] wq_head, rq_head;
  logic       wq_empty, wq_full, rq_empty, rq_full;

  assign txi_en_w    = ctrl_q[CTL_TXIE];
  assign tei_en_w    = ctrl_q[CTL_TEIE];
  assign req_wr      = reg_wr && (reg_addr == RA_COND);
  assign done_clr_wr = req_wr && !reg_wdata[COND_DONE];
  assign stat_wr     = reg_wr && (reg_addr == RA_STAT);
  assign ctrl_wr     = reg_wr && (reg_addr == RA_CTRL);
  assign ack_ev      = ctrl_wr && reg_wdata[CTL_ACK];
  assign rd_data     = reg_rd && (reg_addr == RA_DATA);

  assign data_ok  = reg_wr && (reg_addr == RA_DATA) && ctrl_q[CTL_TXEN] && (cond_pend == 3'd0);
  assign kind     = classify_byte(txn_active, txn_read, reg_wdata);
  assign addr_ev  = data_ok && (kind == BK_ADDR);
  assign pay_ev   = data_ok && (kind == BK_PAYLOAD) && !wq_full;
  assign dummy_ev = data_ok && (kind == BK_DUMMY);

  assign rx_push_ok = bus_rd_valid_i && txn_active && txn_read && !rq_full && !rx_clr;

  i2cs_txn_tracker u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_ev   (addr_ev),
    .addr_byte (reg_wdata),
    .cond_done (cond_complete),
    .active    (txn_active),
    .is_read   (txn_read),
    .tgt       (txn_tgt)
  );

  i2cs_cond_engine u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_wr    (req_wr),
    .req_bits  (reg_wdata[2:0]),
    .active    (txn_active),
    .is_read   (txn_read),
    .wq_empty  (wq_empty),
    .pend      (cond_pend),
    .complete  (cond_complete),
    .flush_pop (flush_pop),
    .multi_ev  (multi_ev),
    .notgt_ev  (notgt_ev),
    .end_ev    (end_ev),
    .rx_clr    (rx_clr),
    .wq_clr    (wq_clr)
  );

  i2cs_fifo #(.WIDTH(8), .DEPTH(WQ_DEPTH)) u_wq (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (wq_clr),
    .push  (pay_ev),
    .din   (reg_wdata),
    .pop   (flush_pop),
    .dout  (wq_head),
    .empty (wq_empty),
    .full  (wq_full)
  );

  i2cs_fifo #(.WIDTH(8), .DEPTH(RQ_DEPTH)) u_rq (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (rx_clr),
    .push  (rx_push_ok),
    .din   (bus_rd_data_i),
    .pop   (rd_data),
    .dout  (rq_head),
    .empty (rq_empty),
    .full  (rq_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      done_q      <= 1'b0;
      err_multi_q <= 1'b0;
      err_notgt_q <= 1'b0;
      txi_q       <= 1'b0;
      rxi_q       <= 1'b0;
      rdreq_q     <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= reg_wdata[CTL_W-1:0];

      if (cond_complete)               done_q <= 1'b1;
      else if (addr_ev || done_clr_wr) done_q <= 1'b0;

      if (multi_ev)                            err_multi_q <= 1'b1;
      else if (stat_wr && reg_wdata[ST_EMULTI]) err_multi_q <= 1'b0;

      if (notgt_ev)                             err_notgt_q <= 1'b1;
      else if (stat_wr && reg_wdata[ST_ENOTGT]) err_notgt_q <= 1'b0;

      txi_q   <= txi_en_w && (addr_ev || pay_ev || dummy_ev || rd_data || ack_ev);
      rxi_q   <= ctrl_q[CTL_RXIE] && rx_push_ok;
      rdreq_q <= dummy_ev;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    case (reg_addr)
      RA_DATA: reg_rdata = rq_empty ? 8'h00 : rq_head;
      RA_COND: reg_rdata = {4'b0000, done_q, cond_pend};
      RA_CTRL: reg_rdata = {{(8-CTL_W){1'b0}}, ctrl_q};
      default: reg_rdata = {3'b000, !rq_empty, err_notgt_q, err_multi_q, txn_read, txn_active};
    endcase
  end

  assign txi_o          = txi_q;
  assign rxi_o          = rxi_q;
  assign tei_o          = tei_en_w && done_q;
  assign bus_tgt_o      = txn_tgt;
  assign bus_wr_valid_o = flush_pop;
  assign bus_wr_data_o  = flush_pop ? wq_head : 8'h00;
  assign bus_rd_req_o   = rdreq_q;
  assign bus_end_o      = end_ev;
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic [2:0] cond_pend,
  input logic       cond_complete,
  input logic       txn_active,
  input logic       txn_read,
  input logic       done_q,
  input logic       txi_en,
  input logic       txi_o,
  input logic       tei_o,
  input logic       bus_end_o,
  input logic       bus_wr_valid_o,
  input logic       bus_rd_req_o
);
  assert_pend_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cond_pend));

  assert_done_after_cond_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cond_complete |=> done_q);

  assert_multi_no_cond_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1 && $countones(reg_wdata[2:0]) > 1 && cond_pend == 3'd0)
      |=> cond_pend == 3'd0);

  assert_idle_after_cond_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cond_complete |=> (!txn_active && !txn_read));

  assert_wr_only_drain_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_valid_o |-> (cond_pend[1] || cond_pend[2]));

  assert_end_has_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_end_o |-> (txn_active && cond_pend[2]));

  assert_rdreq_in_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_req_o |-> $past(txn_active && txn_read));

  assert_txi_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
    txi_o |-> $past(txi_en));

  assert_tei_needs_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tei_o |-> done_q);
endmodule

bind i2c_seq_ctrl i2cs_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .reg_wr         (reg_wr),
  .reg_addr       (reg_addr),
  .reg_wdata      (reg_wdata),
  .cond_pend      (cond_pend),
  .cond_complete  (cond_complete),
  .txn_active     (txn_active),
  .txn_read       (txn_read),
  .done_q         (done_q),
  .txi_en         (txi_en_w),
  .txi_o          (txi_o),
  .tei_o          (tei_o),
  .bus_end_o      (bus_end_o),
  .bus_wr_valid_o (bus_wr_valid_o),
  .bus_rd_req_o   (bus_rd_req_o)
);

// File: tb/tb_i2c_seq_ctrl.sv
`timescale 1ns/1ps
module tb_i2c_seq_ctrl;
  localparam real CLK_HALF = 2.5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       txi_o, rxi_o, tei_o;
  logic [6:0] bus_tgt_o;
  logic       bus_wr_valid_o, bus_rd_req_o, bus_end_o;
  logic [7:0] bus_wr_data_o;
  logic       bus_rd_valid_i = 1'b0;
  logic [7:0] bus_rd_data_i = 8'h00;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_HALF) clk = ~clk;

  i2c_seq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .txi_o(txi_o), .rxi_o(rxi_o),
    .tei_o(tei_o), .bus_tgt_o(bus_tgt_o), .bus_wr_valid_o(bus_wr_valid_o),
    .bus_wr_data_o(bus_wr_data_o), .bus_rd_req_o(bus_rd_req_o),
    .bus_rd_valid_i(bus_rd_valid_i), .bus_rd_data_i(bus_rd_data_i), .bus_end_o(bus_end_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic target_reply(input logic [7:0] d);
    bus_rd_valid_i = 1'b1; bus_rd_data_i = d;
    @(negedge clk);
    bus_rd_valid_i = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    peek(2'd1, v); chk("R1", "cond reg", v, 8'h00);
    peek(2'd2, v); chk("R1", "ctrl reg", v, 8'h00);
    peek(2'd3, v); chk("R1", "status reg", v, 8'h00);
    chk("R1", "irq outputs", {txi_o, rxi_o, tei_o}, 0);
    chk("R1", "bus outputs", {bus_wr_valid_o, bus_rd_req_o, bus_end_o, bus_tgt_o}, 0);
  endtask

  task automatic t_write_txn;
    logic [7:0] v;
    wreg(2'd2, 8'h07);
    wreg(2'd1, 8'h01);
    peek(2'd1, v); chk("R6", "start pending", v, 8'h01);
    @(negedge clk);
    peek(2'd1, v); chk("R6", "start done flag", v, 8'h08);
    chk("R11", "tei after start", tei_o, 1);
    wreg(2'd0, 8'hA4);
    chk("R12", "txi on address", txi_o, 1);
    chk("R2", "tei cleared by address", tei_o, 0);
    peek(2'd3, v); chk("R2", "status write txn", v, 8'h01);
    chk("R2", "target", bus_tgt_o, 7'h52);
    wreg(2'd0, 8'h10);
    chk("R12", "txi on payload", txi_o, 1);
    wreg(2'd0, 8'h3C);
    chk("R3", "no bus write before stop", bus_wr_valid_o, 0);
    wreg(2'd1, 8'h04);
    chk("R3", "drain byte0 valid", bus_wr_valid_o, 1);
    chk("R3", "drain byte0", bus_wr_data_o, 8'h10);
    chk("R3", "target held during drain", bus_tgt_o, 7'h52);
    @(negedge clk);
    chk("R3", "drain byte1 valid", bus_wr_valid_o, 1);
    chk("R3", "drain byte1", bus_wr_data_o, 8'h3C);
    @(negedge clk);
    chk("R3", "drain over", bus_wr_valid_o, 0);
    chk("R9", "end pulse on stop", bus_end_o, 1);
    @(negedge clk);
    chk("R9", "end pulse one cycle", bus_end_o, 0);
    peek(2'd1, v); chk("R6", "stop done", v, 8'h08);
    peek(2'd3, v); chk("R8", "status idle", v, 8'h00);
    chk("R8", "target cleared", bus_tgt_o, 0);
    chk("R11", "tei after stop", tei_o, 1);
    wreg(2'd1, 8'h08);
    peek(2'd1, v); chk("R6", "write 1 keeps flag", v, 8'h08);
    wreg(2'd1, 8'h00);
    peek(2'd1, v); chk("R6", "write 0 clears flag", v, 8'h00);
    chk("R11", "tei low after clear", tei_o, 0);
  endtask

  task automatic t_read_txn;
    logic [7:0] v;
    wreg(2'd2, 8'h0B);
    wreg(2'd0, 8'hA5);
    peek(2'd3, v); chk("R2", "status read txn", v, 8'h03);
    wreg(2'd0, 8'h33);
    chk("R4", "non-dummy no request", bus_rd_req_o, 0);
    chk("R4", "non-dummy no txi", txi_o, 0);
    chk("R4", "no write bus in read", bus_wr_valid_o, 0);
    wreg(2'd0, 8'hFF);
    chk("R4", "dummy request", bus_rd_req_o, 1);
    chk("R12", "txi on dummy", txi_o, 1);
    target_reply(8'h5A);
    chk("R4", "request one cycle", bus_rd_req_o, 0);
    chk("R5", "rxi pulse", rxi_o, 1);
    wreg(2'd0, 8'hFF); target_reply(8'hC3);
    wreg(2'd0, 8'hFF); target_reply(8'h77);
    peek(2'd3, v); chk("R5", "rx available", v, 8'h13);
    rreg(2'd0, v); chk("R5", "first rx byte", v, 8'h5A);
    chk("R12", "txi on data read", txi_o, 1);
    rreg(2'd0, v); chk("R5", "second rx byte", v, 8'hC3);
    wreg(2'd1, 8'h04);
    chk("R9", "end pulse read stop", bus_end_o, 1);
    @(negedge clk);
    peek(2'd3, v); chk("R9", "unread discarded", v, 8'h00);
    peek(2'd0, v); chk("R5", "empty read zero", v, 8'h00);
    wreg(2'd1, 8'h00);
  endtask

  task automatic t_restart;
    logic [7:0] v;
    wreg(2'd2, 8'h03);
    wreg(2'd0, 8'h90);
    wreg(2'd0, 8'h2E);
    wreg(2'd1, 8'h02);
    chk("R3", "restart drains", bus_wr_data_o, 8'h2E);
    chk("R9", "restart no end", bus_end_o, 0);
    @(negedge clk);
    chk("R9", "restart completes no end", bus_end_o, 0);
    @(negedge clk);
    peek(2'd1, v); chk("R6", "restart done", v, 8'h08);
    peek(2'd3, v); chk("R8", "idle after restart", v, 8'h00);
    wreg(2'd0, 8'h91);
    chk("R2", "readdress target", bus_tgt_o, 7'h48);
    peek(2'd1, v); chk("R2", "flag cleared by address", v, 8'h00);
    wreg(2'd1, 8'h04);
    @(negedge clk);
    wreg(2'd1, 8'h00);
  endtask

  task automatic t_notarget;
    logic [7:0] v;
    wreg(2'd1, 8'h04);
    chk("R10", "no end without target", bus_end_o, 0);
    chk("R10", "no write without target", bus_wr_valid_o, 0);
    @(negedge clk);
    peek(2'd1, v); chk("R10", "flag set", v, 8'h08);
    peek(2'd3, v); chk("R10", "no-target error", v, 8'h08);
    wreg(2'd3, 8'h08);
    peek(2'd3, v); chk("R10", "error cleared", v, 8'h00);
    wreg(2'd1, 8'h00);
  endtask

  task automatic t_multi;
    logic [7:0] v;
    wreg(2'd1, 8'h05);
    peek(2'd1, v); chk("R7", "no request latched", v, 8'h00);
    peek(2'd3, v); chk("R7", "multi error", v, 8'h04);
    @(negedge clk);
    peek(2'd1, v); chk("R7", "no completion", v, 8'h00);
    wreg(2'd3, 8'h04);
    peek(2'd3, v); chk("R7", "multi error cleared", v, 8'h00);
  endtask

  task automatic t_gating;
    logic [7:0] v;
    wreg(2'd2, 8'h02);
    wreg(2'd0, 8'hA4);
    chk("R13", "disabled write no txi", txi_o, 0);
    peek(2'd3, v); chk("R13", "disabled write ignored", v, 8'h00);
    wreg(2'd2, 8'h03);
    wreg(2'd0, 8'hA4);
    for (int i = 1; i <= 5; i++) begin
      wreg(2'd0, 8'(i));
      chk("R13", $sformatf("payload %0d txi", i), txi_o, (i <= 4) ? 1 : 0);
    end
    wreg(2'd1, 8'h04);
    for (int i = 1; i <= 4; i++) begin
      chk("R3", $sformatf("drain byte %0d", i), {bus_wr_valid_o, bus_wr_data_o}, {1'b1, 8'(i)});
      @(negedge clk);
    end
    chk("R13", "fifth byte dropped", {bus_wr_valid_o, bus_end_o}, 2'b01);
    @(negedge clk);
    wreg(2'd1, 8'h00);
  endtask

  task automatic t_start_discard;
    logic [7:0] v;
    wreg(2'd0, 8'hA4);
    wreg(2'd0, 8'h11);
    wreg(2'd0, 8'h22);
    wreg(2'd1, 8'h01);
    chk("R14", "start no drain", {bus_wr_valid_o, bus_end_o}, 0);
    @(negedge clk);
    peek(2'd1, v); chk("R14", "start done", v, 8'h08);
    peek(2'd3, v); chk("R14", "idle after start", v, 8'h00);
    wreg(2'd0, 8'hA4);
    wreg(2'd1, 8'h04);
    chk("R14", "queue discarded", {bus_wr_valid_o, bus_end_o}, 2'b01);
    @(negedge clk);
    wreg(2'd1, 8'h00);
  endtask

  task automatic t_ack;
    logic [7:0] v;
    wreg(2'd2, 8'h13);
    chk("R12", "ack write txi", txi_o, 1);
    peek(2'd2, v); chk("R12", "ack bit reads 0", v, 8'h03);
    wreg(2'd2, 8'h01);
    wreg(2'd2, 8'h11);
    chk("R12", "ack gated off", txi_o, 0);
    rreg(2'd0, v);
    chk("R12", "read gated off", txi_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_txn();
    t_read_txn();
    t_restart();
    t_notarget();
    t_multi();
    t_gating();
    t_start_discard();
    t_ack();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule